// File: doc/BRIEF.md
# General-Purpose Timer Unit with Reload/Capture Auxiliaries

This block is a three-counter timer unit. It has one core counter and two auxiliary counters, all 16 bits wide. Each counter has its own control register. That register picks the count source, the direction, the run state and the mode. The count source is either a tick taken from a shared free-running prescaler (one tick every 2^n system clocks) or the rising edges of a synchronised external count pin. An external direction pin per counter can take over the direction setting.

The auxiliary counters work alongside the core. An auxiliary counter in capture mode takes a snapshot of the core value on its pin edge. An auxiliary counter in reload mode hands its own value to the core on every second core wrap. The core drives a toggle output that changes state on each of its overflows and underflows. Every counter pulses its own interrupt line for one cycle on its events. Software reaches the six registers through a single-cycle write strobe and a registered read port.

Top module: `gpt_timer_unit`

## Requirements
- R1: Registers sit at addr = 2*u (value) and 2*u+1 (control), where unit u=0 is the core and u=1, u=2 are the auxiliaries. Addresses 6 and 7 read as zero and ignore writes. rd_data shows the register selected by addr one cycle after addr is presented. Control reads back as its 9 low bits, zero-extended. Reset clears every register, rd_data, irq and toggle_out.
- R2: The control fields are psel=[3:0], mode=[5:4], run=[6], down=[7] and pin-direction enable=[8]. In timer mode (0) a running counter steps once every 2^n clocks. n is psel clamped into 2..12, and the prescaler phase is shared and counts from reset.
- R3: In event mode (1) a running counter steps once per rising edge of its cnt_in bit after a two-flop synchroniser.
- R4: down=1 counts down and down=0 counts up. When bit 8 is set, the synchronised dir_in bit sets the direction instead (1 means down).
- R5: Counting up from 0xFFFF gives 0x0000, and counting down from 0x0000 gives 0xFFFF. Each such wrap pulses that counter's irq bit.
- R6: toggle_out inverts on every core wrap and on nothing else.
- R7: An auxiliary counter in capture mode (2) with run set does not count. On each synchronised rising edge of its cnt_in bit it copies the current core value and pulses its irq bit.
- R8: When the core wraps while toggle_out is 0, and some auxiliary counter is running in reload mode (3), the core takes that counter's value instead of the wrapped value, and that counter pulses its irq bit. Unit 1 wins over unit 2. An auxiliary counter in reload mode does not count.
- R9: A software write to a value register overrides a step, capture or reload in the same cycle, and that cycle raises no wrap event.
- R10: With run=0 a counter neither steps nor captures.
- R11: Every irq bit is a single-cycle pulse.
- R12: The core treats modes 2 and 3 as timer mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select for write and read |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| cnt_in | input | 3 | External count pins, one per unit |
| dir_in | input | 3 | External direction pins, one per unit (1 = down) |
| irq | output | 3 | Interrupt request pulses, one per unit |
| toggle_out | output | 1 | Core overflow/underflow toggle |

## Verification
The bench builds the unit with its defaults: 16-bit counters, a prescaler range of 2 to 12 and two auxiliary counters. Software can preload a value next to 0xFFFF or 0x0000, so wraps, toggles and reload chains show up within tens of cycles at psel 2. A psel of 15 clamps to 12 and still completes two 4096-clock ticks well inside the run. With two auxiliaries, the reload priority between units 1 and 2 and the hand-over when unit 1 stops running can both be driven directly.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam int PSEL_W = 4;

  typedef enum logic [1:0] {
    MODE_TIMER   = 2'd0,
    MODE_EVENT   = 2'd1,
    MODE_CAPTURE = 2'd2,
    MODE_RELOAD  = 2'd3
  } mode_e;

  // packed MSB first: bit 8 pin-direction enable ... bits 3:0 prescale select
  typedef struct packed {
    logic              pin_dir;
    logic              down;
    logic              run;
    mode_e             mode;
    logic [PSEL_W-1:0] psel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/gpt_sync_edge.sv
module gpt_sync_edge #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;

endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int N_MIN = 2,
  parameter int N_MAX = 12,
  parameter int UNITS = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [UNITS-1:0][gpt_pkg::PSEL_W-1:0] psel,
  output logic [UNITS-1:0]                    tick
);

  logic [N_MAX-1:0] ring_q;

  always_ff @(posedge clk) begin
    if (rst) ring_q <= '0;
    else     ring_q <= ring_q + N_MAX'(1);
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_tick
    int               n_eff;
    logic [N_MAX-1:0] mask;

    always_comb begin
      if (int'(psel[u]) < N_MIN)      n_eff = N_MIN;
      else if (int'(psel[u]) > N_MAX) n_eff = N_MAX;
      else                            n_eff = int'(psel[u]);
      for (int b = 0; b < N_MAX; b++) mask[b] = (b < n_eff);
    end

    assign tick[u] = ((ring_q & mask) == mask);
  end

endmodule

// File: rtl/gpt_count_unit.sv
module gpt_count_unit
  import gpt_pkg::*;
#(
  parameter int W       = 16,
  parameter bit IS_CORE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         ev_rise,
  input  logic         dir_lvl,
  input  logic         wr_val,
  input  logic         wr_ctrl,
  input  logic [W-1:0] wdata,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cap_src,
  output logic [W-1:0] val,
  output ctrl_t        ctrl,
  output logic         wrap,
  output logic         cap_evt
);

  logic step;
  logic going_down;
  logic at_edge;

  always_comb begin
    step = 1'b0;
    if (ctrl.run) begin
      case (ctrl.mode)
        MODE_TIMER: step = tick;
        MODE_EVENT: step = ev_rise;
        default:    step = IS_CORE ? tick : 1'b0;
      endcase
    end
  end

  assign going_down = ctrl.pin_dir ? dir_lvl : ctrl.down;
  assign at_edge    = going_down ? (val == '0) : (val == '1);
  assign wrap       = step & at_edge & ~wr_val;
  assign cap_evt    = !IS_CORE && ctrl.run && (ctrl.mode == MODE_CAPTURE)
                      && ev_rise && !wr_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      val  <= '0;
      ctrl <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_val)       val <= wdata;
      else if (load_en) val <= load_val;
      else if (cap_evt) val <= cap_src;
      else if (step)    val <= going_down ? val - W'(1) : val + W'(1);
    end
  end

endmodule

// File: rtl/gpt_timer_unit.sv
module gpt_timer_unit
  import gpt_pkg::*;
#(
  parameter  int W     = 16,
  parameter  int N_MIN = 2,
  parameter  int N_MAX = 12,
  parameter  int N_AUX = 2,
  localparam int UNITS = N_AUX + 1,
  localparam int AW    = $clog2(2 * UNITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rd_data,
  input  logic [UNITS-1:0] cnt_in,
  input  logic [UNITS-1:0] dir_in,
  output logic [UNITS-1:0] irq,
  output logic             toggle_out
);

  logic [UNITS-1:0]              cnt_lvl, cnt_rise, dir_lvl, dir_rise;
  logic [UNITS-1:0]              tick;
  logic [UNITS-1:0][PSEL_W-1:0]  psel_v;
  logic [UNITS-1:0]              wr_val, wr_ctrl;
  logic [UNITS-1:0]              wrap, cap_evt, evt;
  logic [UNITS-1:0]              rl_pick;
  logic                          rl_found, reload_fire;
  logic [W-1:0]                  rl_val, rd_mux;
  logic [W-1:0]                  val_q  [UNITS];
  ctrl_t                         ctrl_q [UNITS];

  gpt_sync_edge #(.WIDTH(UNITS)) u_cnt_sync (
    .clk(clk), .rst(rst), .pin(cnt_in), .level(cnt_lvl), .rise(cnt_rise));

  gpt_sync_edge #(.WIDTH(UNITS)) u_dir_sync (
    .clk(clk), .rst(rst), .pin(dir_in), .level(dir_lvl), .rise(dir_rise));

  gpt_prescaler #(.N_MIN(N_MIN), .N_MAX(N_MAX), .UNITS(UNITS)) u_presc (
    .clk(clk), .rst(rst), .psel(psel_v), .tick(tick));

  always_comb begin
    for (int u = 0; u < UNITS; u++) begin
      psel_v[u]  = ctrl_q[u].psel;
      wr_val[u]  = wr_en && (addr == AW'(2 * u));
      wr_ctrl[u] = wr_en && (addr == AW'(2 * u + 1));
    end
  end

  // lowest auxiliary index in reload mode is the reload source
  always_comb begin
    rl_pick  = '0;
    rl_found = 1'b0;
    rl_val   = '0;
    for (int u = 1; u < UNITS; u++) begin
      if (!rl_found && ctrl_q[u].run && ctrl_q[u].mode == MODE_RELOAD) begin
        rl_pick[u] = 1'b1;
        rl_found   = 1'b1;
        rl_val     = val_q[u];
      end
    end
  end

  assign reload_fire = wrap[0] & ~toggle_out & rl_found;

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    gpt_count_unit #(.W(W), .IS_CORE(u == 0)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick[u]),
      .ev_rise (cnt_rise[u]),
      .dir_lvl (dir_lvl[u]),
      .wr_val  (wr_val[u]),
      .wr_ctrl (wr_ctrl[u]),
      .wdata   (wdata),
      .load_en ((u == 0) ? reload_fire : 1'b0),
      .load_val(rl_val),
      .cap_src (val_q[0]),
      .val     (val_q[u]),
      .ctrl    (ctrl_q[u]),
      .wrap    (wrap[u]),
      .cap_evt (cap_evt[u])
    );

    if (u == 0) begin : g_core_evt
      assign evt[u] = wrap[u];
    end else begin : g_aux_evt
      assign evt[u] = wrap[u] | cap_evt[u] | (reload_fire & rl_pick[u]);
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int u = 0; u < UNITS; u++) begin
      if (addr == AW'(2 * u))     rd_mux = val_q[u];
      if (addr == AW'(2 * u + 1)) rd_mux = {{(W-CTRL_W){1'b0}}, ctrl_q[u]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= '0;
      toggle_out <= 1'b0;
      rd_data    <= '0;
    end else begin
      irq        <= evt;
      toggle_out <= toggle_out ^ wrap[0];
      rd_data    <= rd_mux;
    end
  end

  logic unused_ok;
  assign unused_ok = ^{cnt_lvl, dir_rise, cap_evt[0]};

endmodule

// File: rtl/gpt_timer_unit_chk.sv
module gpt_timer_unit_chk #(
  parameter int W     = 16,
  parameter int N_AUX = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [N_AUX:0]   irq,
  input logic             toggle_out,
  input logic [W-1:0]     rd_data
);

  // R1: reset leaves outputs quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (irq == '0 && !toggle_out && rd_data == '0));

  // R11: no irq bit stays high two cycles running
  p_irq_single_r11: assert property (@(posedge clk) disable iff (rst)
    (irq & $past(irq)) == '0);

  // R6: toggle only moves together with a core wrap pulse
  p_toggle_needs_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(toggle_out) |-> irq[0]);

  // R6: every core wrap pulse moves the toggle
  p_wrap_moves_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    irq[0] |-> !$stable(toggle_out));

endmodule

bind gpt_timer_unit gpt_timer_unit_chk #(.W(W), .N_AUX(N_AUX)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .toggle_out(toggle_out), .rd_data(rd_data));

// File: tb/tb_gpt_timer_unit.sv
`timescale 1ns/1ps
module tb_gpt_timer_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rd_data;
  logic [2:0]  cnt_in = '0;
  logic [2:0]  dir_in = '0;
  logic [2:0]  irq;
  logic        toggle_out;

  always #4 clk = ~clk;   // 125 MHz

  gpt_timer_unit dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .cnt_in(cnt_in), .dir_in(dir_in), .irq(irq),
    .toggle_out(toggle_out));

  int    n_chk = 0, n_bad = 0, cyc = 0;
  string tag = "R1";

  // behavioural reference state
  int          m_pre;
  logic [2:0]  m_s1, m_s2, m_prev, m_d1, m_d2;
  logic [15:0] m_val [3];
  logic [8:0]  m_ctl [3];
  logic        m_tff;
  logic [2:0]  m_irq;
  logic [15:0] m_rd;

  always @(posedge clk) begin : model
    logic [15:0] nv [3];
    logic [2:0]  ev, wrp;
    logic [15:0] rdn;
    int n, pick, md;
    logic stp, dn, rise, hitw, run;
    cyc++;
    if (rst) begin
      m_pre = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_d1 = 0; m_d2 = 0;
      for (int u = 0; u < 3; u++) begin m_val[u] = 0; m_ctl[u] = 0; end
      m_tff = 0; m_irq = 0; m_rd = 0;
    end else begin
      ev = 0; wrp = 0; pick = -1;
      rdn = 0;
      if (addr < 6) rdn = addr[0] ? {7'b0, m_ctl[addr >> 1]} : m_val[addr >> 1];
      for (int u = 0; u < 3; u++) begin
        nv[u] = m_val[u];
        n = int'(m_ctl[u][3:0]);
        if (n < 2) n = 2;
        if (n > 12) n = 12;
        rise = m_s2[u] & ~m_prev[u];
        dn   = m_ctl[u][8] ? m_d2[u] : m_ctl[u][7];
        md   = int'(m_ctl[u][5:4]);
        run  = m_ctl[u][6];
        stp  = 0;
        if (run) begin
          if (md == 1) stp = rise;
          else if (md == 0 || u == 0) stp = ((m_pre % (1 << n)) == (1 << n) - 1);
        end
        hitw = wr_en && (int'(addr) == 2 * u);
        if (hitw) nv[u] = wdata;
        else if (u > 0 && run && md == 2 && rise) begin nv[u] = m_val[0]; ev[u] = 1; end
        else if (stp) begin
          if (dn) begin if (m_val[u] == 16'h0000) wrp[u] = 1; nv[u] = m_val[u] - 1; end
          else    begin if (m_val[u] == 16'hFFFF) wrp[u] = 1; nv[u] = m_val[u] + 1; end
        end
      end
      if (wrp[0] && !m_tff)
        for (int u = 2; u >= 1; u--)
          if (m_ctl[u][6] && m_ctl[u][5:4] == 2'd3) pick = u;
      if (pick > 0) begin nv[0] = m_val[pick]; ev[pick] = 1; end
      ev = ev | wrp;
      if (wr_en && addr[0] && addr < 6) m_ctl[addr >> 1] = wdata[8:0];
      m_irq = ev;
      m_tff = m_tff ^ wrp[0];
      m_rd  = rdn;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = cnt_in;
      m_d2 = m_d1; m_d1 = dir_in;
      m_pre = (m_pre + 1) % 4096;
      for (int u = 0; u < 3; u++) m_val[u] = nv[u];
    end
  end

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 0) begin
      chk("rd_data", rd_data, m_rd);
      chk("irq", {13'b0, irq}, {13'b0, m_irq});
      chk("toggle_out", {15'b0, toggle_out}, {15'b0, m_tff});
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL %s watchdog: actual %0d cycles expected under 150000", tag, cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sel(int a);
    @(negedge clk);
    addr = 3'(a);
  endtask

  task automatic pulse(int idx, int hi, int lo);
    @(negedge clk);
    cnt_in[idx] = 1'b1;
    wait_n(hi);
    cnt_in[idx] = 1'b0;
    wait_n(lo);
  endtask

  initial begin
    wait_n(4);
    rst = 1'b0;

    // R1: reset values, map, readback, unused addresses
    tag = "R1";
    for (int a = 0; a < 8; a++) begin sel(a); wait_n(2); end
    wr(1, 16'h0035); wr(2, 16'h1234); wr(5, 16'hFFFF); wr(6, 16'hBEEF); wr(7, 16'h00AA);
    for (int a = 0; a < 8; a++) begin sel(a); wait_n(2); end
    wr(1, 0); wr(2, 0); wr(5, 0);

    // R2: prescaled timer, several psel values incl. clamps
    tag = "R2";
    wr(0, 16'hFFF0); wr(1, 16'h0042); sel(0); wait_n(80);
    wr(1, 16'h0040); wait_n(40);
    wr(1, 16'h0043); wait_n(100);
    wr(0, 16'hFFFE); wr(1, 16'h004F); wait_n(9000);

    // R12: core modes 2 and 3 count like timer
    tag = "R12";
    wr(0, 16'hFFF8); wr(1, 16'h0062); sel(0); wait_n(50);
    wr(1, 16'h0072); wait_n(50);

    // R4: direction bit and pin override
    tag = "R4";
    wr(0, 16'h0005); wr(1, 16'h00C2); sel(0); wait_n(40);
    wr(1, 16'h0142);
    for (int k = 0; k < 10; k++) begin dir_in[0] = ~dir_in[0]; wait_n(13); end
    dir_in[0] = 1'b0;

    // R3: event counting on synchronised rising edges
    tag = "R3";
    wr(0, 16'hFFFD); wr(1, 16'h0050); sel(0);
    for (int k = 0; k < 8; k++) pulse(0, 1 + k % 3, 1 + k % 2);
    wr(1, 16'h00D0); wr(0, 16'h0002);
    for (int k = 0; k < 6; k++) pulse(0, 2, 3);

    // R10: stopped counter ignores ticks and edges
    tag = "R10";
    wr(1, 16'h0002); wait_n(30);
    for (int k = 0; k < 4; k++) pulse(0, 1, 2);
    wr(3, 16'h0020); sel(2);
    for (int k = 0; k < 4; k++) pulse(1, 1, 2);

    // R5: auxiliary wraps up and down
    tag = "R5";
    wr(2, 16'hFFF0); wr(3, 16'h0042); sel(2); wait_n(100);
    wr(4, 16'h0002); wr(5, 16'h00D0); sel(4);
    for (int k = 0; k < 6; k++) pulse(2, 1, 1);
    wr(3, 0); wr(5, 0);

    // R6: toggle follows core wraps
    tag = "R6";
    wr(0, 16'hFFFC); wr(1, 16'h0042); sel(0); wait_n(200);

    // R7: capture of the running core value
    tag = "R7";
    wr(0, 16'h0100); wr(3, 16'h0060); sel(2);
    for (int k = 0; k < 6; k++) pulse(1, 1 + k % 2, 3 + 2 * k);
    wr(3, 0);

    // R8: reload on rising toggle, priority of unit 1 over unit 2
    tag = "R8";
    wr(4, 16'hFFF0); wr(5, 16'h0070); wr(0, 16'hFFFC); sel(0); wait_n(200);
    wr(2, 16'hFF00); wr(3, 16'h0070); wait_n(200);
    sel(4); wait_n(20);
    wr(3, 16'h0030); sel(0); wait_n(150);
    wr(3, 0); wr(5, 0);

    // R9: writes override counting and capture
    tag = "R9";
    wr(1, 16'h0042); sel(0);
    for (int k = 0; k < 30; k++) wr(0, 16'hFFFF);
    wr(3, 16'h0060);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); cnt_in[1] = 1'b1;
      wr(2, 16'h0A0A + k);
      cnt_in[1] = 1'b0;
      wait_n(k);
    end
    sel(2); wait_n(4);
    wr(3, 0);

    // R11: fastest event rates keep pulses single-cycle
    tag = "R11";
    wr(0, 16'hFFFE); wr(2, 16'hFFFE); wr(4, 16'h0001);
    wr(1, 16'h0050); wr(3, 16'h0050); wr(5, 16'h00D0);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); cnt_in = 3'b111;
      @(negedge clk); cnt_in = 3'b000;
    end
    wait_n(10);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule